// File: doc/BRIEF.md
# Bouncing Snake Bar Controller

The block drives a row of position outputs in which one contiguous run of set bits, the snake, moves one position each time an internal step enable fires. The snake travels toward one end of the row. When its head lands on the last position in that direction, it turns around and travels back. A one-cycle length request makes the snake one bit longer. A request made at the longest length trims it back to the shortest length. Everything runs on one fast clock. An internal free-running counter sets the pace of motion, and the length request is sampled on that same clock. One register holds the position, and only one piece of logic ever writes it.

The snake runs from a minimum of 2 bits up to a maximum of 6 bits. The row is 18 positions wide by default. The step period is a parameter. Its large default gives visible motion from a 50 MHz clock, and a bench can set it small. The length request must already be clean and one cycle wide, because the block does no debouncing. The block has no data stream, so it has no handshake and never applies back-pressure. Its pins are plain control and status signals.

Top module: `bouncing_snake_bar`

## Requirements
- R1: While `rst` is high at a clock edge, the next output is `pos` = bits 0 and 1 set (value 3). The direction becomes toward the MSB and the step counter clears. The first step after reset is taken on the STEP_PERIOD-th clock edge with `rst` low.
- R2: A step happens on every STEP_PERIOD-th edge after reset and on no other edge. On an edge with no step and no length request, `pos` keeps its value.
- R3: A step while heading toward the MSB moves every set bit up by one position (`pos` becomes `pos << 1`).
- R4: When the head of the snake lands on bit WIDTH-1, the direction becomes toward the LSB, and later steps use `pos >> 1`. When the head lands on bit 0, the direction becomes toward the MSB. As a result, whenever bit WIDTH-1 is set the direction is toward the LSB, and whenever bit 0 is set the direction is toward the MSB.
- R5: Below the maximum length, a request adds one bit at the tail. Heading toward the MSB, the new bit goes just below the lowest set bit. Heading toward the LSB, it goes just above the highest set bit. If the tail already sits on the end bit of the row, the new bit goes beside the head instead.
- R6: Starting from length 2, successive requests give lengths 3, 4, 5, 6. A request at length 6 sets the length to 2 and keeps the two bits at the head: the highest two when heading toward the MSB, the lowest two when heading toward the LSB.
- R7: When a request and a step fall on the same edge, the length change is applied first and the shifted result is then stored. Neither event is lost.
- R8: At all times outside reset, `pos` holds one contiguous run of set bits whose count lies between 2 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| len_req | input | 1 | One-cycle request to change the snake length |
| pos | output | WIDTH (18) | Position vector; set bits form the snake |

## Verification
The bound checker watches, on every cycle, that the snake stays one contiguous run inside the length limits. It also checks that the output holds still when neither a step nor a request occurs, that a step toward the MSB is a one-position shift, that a bit set on either end of the row always pairs with the direction pointing away from that end, and that each request either adds one bit or drops back to the minimum length. Several behaviours are shown only by the bench's scenarios: the exact placement of an added bit at the tail or beside the head when the tail touches a wall, which two bits survive a trim, the edge on which the first step lands after reset, and the ordering when a request meets a step. The bench compares the output with its own model on every cycle of a stimulus table, and then runs directed cases at the walls.

// File: rtl/snake_bar_pkg.sv
package snake_bar_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/snake_step_timer.sv
module snake_step_timer #(
  parameter int STEP_PERIOD = 33554432
) (
  input  logic clk,
  input  logic rst,
  output logic step_en
);

  localparam int CW = (STEP_PERIOD > 1) ? $clog2(STEP_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_PERIOD - 1);

  generate
    if (STEP_PERIOD <= 1) begin : g_every_cycle
      assign step_en = 1'b1;
    end else begin : g_counted
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign step_en = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/snake_length_unit.sv
module snake_length_unit
  import snake_bar_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 6,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic [WIDTH-1:0] pos_in,
  input  dir_e             dir,
  input  logic [LW-1:0]    len_in,
  input  logic             req,
  output logic [WIDTH-1:0] pos_out,
  output logic [LW-1:0]    len_out
);

  localparam int TRIM = MAX_LEN - MIN_LEN;
  localparam logic [LW-1:0] MAX_L = LW'(MAX_LEN);
  localparam logic [LW-1:0] MIN_L = LW'(MIN_LEN);

  logic [WIDTH-1:0] grow_up, grow_dn, trim_up, trim_dn;

  // Tail sits below the head when heading up; fall back to the head side at the wall.
  assign grow_up = pos_in[0]       ? (pos_in | (pos_in << 1)) : (pos_in | (pos_in >> 1));
  assign grow_dn = pos_in[WIDTH-1] ? (pos_in | (pos_in >> 1)) : (pos_in | (pos_in << 1));
  // Keep only the MIN_LEN bits at the head.
  assign trim_up = pos_in & (pos_in << TRIM);
  assign trim_dn = pos_in & (pos_in >> TRIM);

  always_comb begin
    pos_out = pos_in;
    len_out = len_in;
    if (req) begin
      if (len_in >= MAX_L) begin
        pos_out = (dir == DIR_UP) ? trim_up : trim_dn;
        len_out = MIN_L;
      end else begin
        pos_out = (dir == DIR_UP) ? grow_up : grow_dn;
        len_out = len_in + 1'b1;
      end
    end
  end

endmodule

// File: rtl/snake_motion_unit.sv
module snake_motion_unit
  import snake_bar_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic [WIDTH-1:0] pos_in,
  input  dir_e             dir_in,
  input  logic             step,
  output logic [WIDTH-1:0] pos_out,
  output dir_e             dir_out
);

  always_comb begin
    if (!step) begin
      pos_out = pos_in;
    end else if (dir_in == DIR_UP) begin
      pos_out = pos_in << 1;
    end else begin
      pos_out = pos_in >> 1;
    end
  end

  always_comb begin
    dir_out = dir_in;
    if (dir_in == DIR_UP && pos_out[WIDTH-1]) begin
      dir_out = DIR_DOWN;
    end else if (dir_in == DIR_DOWN && pos_out[0]) begin
      dir_out = DIR_UP;
    end
  end

endmodule

// File: rtl/bouncing_snake_bar.sv
module bouncing_snake_bar
  import snake_bar_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int MIN_LEN     = 2,
  parameter int MAX_LEN     = 6,
  parameter int STEP_PERIOD = 33554432
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_req,
  output logic [WIDTH-1:0] pos
);

  localparam int LW = $clog2(MAX_LEN + 1);
  localparam logic [WIDTH-1:0] RESET_POS = {{(WIDTH-MIN_LEN){1'b0}}, {MIN_LEN{1'b1}}};

  logic [WIDTH-1:0] pos_q, pos_sized, pos_moved;
  logic [LW-1:0]    len_q, len_next;
  dir_e             dir_q, dir_next;
  logic             step_en;

  snake_step_timer #(
    .STEP_PERIOD(STEP_PERIOD)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .step_en(step_en)
  );

  snake_length_unit #(
    .WIDTH  (WIDTH),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN),
    .LW     (LW)
  ) u_length (
    .pos_in (pos_q),
    .dir    (dir_q),
    .len_in (len_q),
    .req    (len_req),
    .pos_out(pos_sized),
    .len_out(len_next)
  );

  snake_motion_unit #(
    .WIDTH(WIDTH)
  ) u_motion (
    .pos_in (pos_sized),
    .dir_in (dir_q),
    .step   (step_en),
    .pos_out(pos_moved),
    .dir_out(dir_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= RESET_POS;
      len_q <= LW'(MIN_LEN);
      dir_q <= DIR_UP;
    end else begin
      pos_q <= pos_moved;
      len_q <= len_next;
      dir_q <= dir_next;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/snake_bar_checker.sv
module snake_bar_checker
  import snake_bar_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             len_req,
  input logic             step_en,
  input dir_e             dir,
  input logic [WIDTH-1:0] pos
);

  localparam logic [WIDTH-1:0] RESET_POS = {{(WIDTH-MIN_LEN){1'b0}}, {MIN_LEN{1'b1}}};

  logic [WIDTH-1:0] fill;
  assign fill = (pos | (pos - 1'b1)) + 1'b1;

  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> (pos == RESET_POS));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !len_req) |=> $stable(pos));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !len_req && dir == DIR_UP) |=> (pos == ($past(pos) << 1)));

  p_top_heads_down_r4: assert property (@(posedge clk) disable iff (rst)
    pos[WIDTH-1] |-> (dir == DIR_DOWN));

  p_bottom_heads_up_r4: assert property (@(posedge clk) disable iff (rst)
    pos[0] |-> (dir == DIR_UP));

  p_grow_one_r5: assert property (@(posedge clk) disable iff (rst)
    (len_req && $countones(pos) < MAX_LEN) |=> ($countones(pos) == $countones($past(pos)) + 1));

  p_wrap_min_r6: assert property (@(posedge clk) disable iff (rst)
    (len_req && $countones(pos) == MAX_LEN) |=> ($countones(pos) == MIN_LEN));

  p_both_change_r7: assert property (@(posedge clk) disable iff (rst)
    (len_req && step_en) |=> !$stable(pos));

  p_contiguous_r8: assert property (@(posedge clk) disable iff (rst)
    (fill & pos) == '0);

  p_len_range_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones(pos) >= MIN_LEN) && ($countones(pos) <= MAX_LEN));

endmodule

bind bouncing_snake_bar snake_bar_checker #(
  .WIDTH  (WIDTH),
  .MIN_LEN(MIN_LEN),
  .MAX_LEN(MAX_LEN)
) u_snake_chk (
  .clk    (clk),
  .rst    (rst),
  .len_req(len_req),
  .step_en(step_en),
  .dir    (dir_q),
  .pos    (pos)
);

// File: tb/bouncing_snake_bar_bench.sv
module bouncing_snake_bar_bench;

  localparam int W = 18;
  localparam int P = 4;
  localparam int MINL = 2;
  localparam int MAXL = 6;
  localparam int NVEC = 20;

  // Each entry: {request, idle cycles before it [3:0]}
  localparam logic [4:0] VEC [NVEC] = '{
    5'h13, 5'h10, 5'h11, 5'h12, 5'h17, 5'h10, 5'h19, 5'h05,
    5'h1F, 5'h1F, 5'h13, 5'h10, 5'h10, 5'h10, 5'h1E, 5'h1C,
    5'h11, 5'h08, 5'h1F, 5'h16
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic len_req = 1'b0;
  logic [W-1:0] pos;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_pos;
  bit m_down;
  int m_cnt;

  always #10 clk = ~clk;

  bouncing_snake_bar #(
    .WIDTH(W), .MIN_LEN(MINL), .MAX_LEN(MAXL), .STEP_PERIOD(P)
  ) u_bouncing_snake_bar (
    .clk(clk), .rst(rst), .len_req(len_req), .pos(pos)
  );

  function automatic int lowest(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int highest(input logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_edge(input logic r, input logic q);
    int lo, hi, n;
    bit stp;
    if (r) begin
      m_pos = W'(3); m_down = 0; m_cnt = 0;
      return;
    end
    lo = lowest(m_pos); hi = highest(m_pos); n = hi - lo + 1;
    if (q) begin
      if (n >= MAXL) begin
        m_pos = '0;
        if (!m_down) begin m_pos[hi] = 1'b1; m_pos[hi-1] = 1'b1; end
        else begin m_pos[lo] = 1'b1; m_pos[lo+1] = 1'b1; end
      end else if (!m_down) begin
        if (lo == 0) m_pos[hi+1] = 1'b1; else m_pos[lo-1] = 1'b1;
      end else begin
        if (hi == W-1) m_pos[lo-1] = 1'b1; else m_pos[hi+1] = 1'b1;
      end
    end
    stp = (m_cnt == P-1);
    m_cnt = stp ? 0 : m_cnt + 1;
    if (stp) m_pos = m_down ? (m_pos >> 1) : (m_pos << 1);
    if (!m_down && m_pos[W-1]) m_down = 1;
    else if (m_down && m_pos[0]) m_down = 0;
  endtask

  task automatic cyc(input logic r, input logic q);
    rst = r; len_req = q;
    @(posedge clk);
    model_edge(r, q);
    @(negedge clk);
    rst = 1'b0; len_req = 1'b0;
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (pos !== exp) begin
      failures++;
      $display("FAIL %s pos=%h expected=%h", tag, pos, exp);
    end
  endtask

  task automatic do_reset();
    cyc(1, 0);
    cyc(1, 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset value", W'(3));

    // R2/R3: first step lands on the 4th edge after reset
    for (int i = 0; i < P-1; i++) cyc(0, 0);
    check("R2 no step before period", W'(3));
    cyc(0, 0);
    check("R3 first step upward", W'(6));

    // R5: tail at the wall, bit goes beside the head
    do_reset();
    cyc(0, 1);
    check("R5 grow at low wall", W'(7));

    // R7: request on the step edge
    do_reset();
    for (int i = 0; i < P-1; i++) cyc(0, 0);
    cyc(0, 1);
    check("R7 grow then shift", W'(14));

    // R6: grow to six then trim keeps head bits
    do_reset();
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    check("R5 length five", W'(31));
    cyc(0, 0);
    check("R3 step with five", W'(62));
    cyc(0, 1);
    check("R5 grow below tail", W'(63));
    cyc(0, 1);
    check("R6 trim keeps top two", W'(48));

    // R4: reach the top and turn back
    do_reset();
    for (int i = 0; i < 16*P; i++) cyc(0, 0);
    check("R4 head at top", W'(18'h30000));
    cyc(0, 1);
    check("R5 grow at high wall", W'(18'h38000));
    for (int i = 0; i < P-1; i++) cyc(0, 0);
    check("R4 first step downward", W'(18'h1C000));

    // Table walk against the bench model, every cycle checked (R2 R3 R4 R5 R6 R8)
    do_reset();
    for (int v = 0; v < NVEC; v++) begin
      for (int h = 0; h < int'(VEC[v][3:0]); h++) begin
        cyc(0, 0);
        check("R2 table idle", m_pos);
      end
      cyc(0, VEC[v][4]);
      check("R6 table request", m_pos);
      checks++;
      if ($countones(pos) < MINL || $countones(pos) > MAXL ||
          (highest(pos) - lowest(pos) + 1) != $countones(pos)) begin
        failures++;
        $display("FAIL R8 pos=%h expected contiguous run of 2..6", pos);
      end
    end
    for (int i = 0; i < 30*P; i++) begin
      cyc(0, 0);
      check("R4 table bounce", m_pos);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule